// File: doc/BRIEF.md
# Four-Master MESI Coherence Hub

This block is the central coherence point for a four-master system. Each master keeps a private write-back cache whose lines are Modified, Exclusive, Shared or Invalid. Before a master touches memory for a coherent access, it raises a broadcast request on its request port. The hub turns that request into a snoop toward every other master. It waits until every one of those masters has answered. It then grants the access with a one-cycle enable pulse back to the initiator.

A write broadcast produces an invalidating snoop: each other cache writes back any dirty copy of the line and drops it. A read broadcast produces a non-invalidating snoop: any cache holding the line Modified writes it back. Plain reads and writes never reach the hub's logic. Only one coherence transaction is handled at a time. A request that is not served at once, because a higher-priority master asked in the same cycle or because the engine is busy, waits in its master's own 16-entry queue. Each queue's occupancy is visible on an output.

Top module: `mesi_hub`

## Requirements
- R1: After reset, every queue count is zero, every `req_ready` bit is 1, and no snoop or enable is driven.
- R2: Request kind codes are 2'b00 plain write and 2'b01 plain read. These produce no snoop, no enable and no queue entry.
- R3: Kind 2'b10 (write broadcast) is accepted at a clock edge. In the next cycle it produces a single one-cycle `snoop_valid` pulse to every master except the initiator, with `snoop_inval`=1 and `snoop_addr` equal to the request address.
- R4: Kind 2'b11 (read broadcast) produces the same snoop fan-out, but with `snoop_inval`=0.
- R5: The enable is a one-cycle pulse on the initiator's bit of `enable_wr` (write broadcast) or `enable_rd` (read broadcast). It appears in the cycle after the edge where the last outstanding snoop acknowledge is sampled. Acknowledges from the initiator or from masters already answered are ignored.
- R6: When several masters present requests to an idle hub in the same cycle, the lowest-numbered master is served first. Each other broadcast request goes into its own master's queue.
- R7: Queued requests of one master are served in arrival order. A non-empty queue's head is served before any new request from that master.
- R8: A queue holding 16 entries drives its `req_ready` bit low. A request offered while that bit is low is dropped.
- R9: Broadcast requests arriving while a transaction is in progress are queued. They start no second snoop before the current enable.
- R10: `queue_count` reports each queue's occupancy (master i in bits [5i+4:5i]), rising by one per accepted queued request and falling by one per served entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 4 | Request present, one bit per master |
| req_kind | input | 8 | Request kind, 2 bits per master |
| req_addr | input | 64 | Request address, 16 bits per master |
| req_ready | output | 4 | Queue of that master has room |
| snoop_valid | output | 4 | One-cycle snoop pulse per target master |
| snoop_inval | output | 1 | 1: invalidating (write) snoop, 0: read snoop |
| snoop_addr | output | 16 | Address of the current snoop |
| snoop_ack | input | 4 | One-cycle snoop response per master |
| enable_wr | output | 4 | Write enable pulse to the initiator |
| enable_rd | output | 4 | Read enable pulse to the initiator |
| queue_count | output | 20 | Occupancy of each queue, 5 bits per master |

## Verification
The bench withholds some acknowledges and repeats the initiator's own acknowledge. A hub that counted pulses instead of masking them would grant early. It raises all four masters in one cycle, where an inverted or rotating priority would snoop the wrong initiator. It also stacks two requests behind a busy transaction; a queue read from the wrong end would serve them out of order. Finally it fills one queue to 16 and offers a seventeenth request. A queue whose full flag is off by one would accept it, and the extra entry would show up as a spurious snoop after draining.

// File: rtl/mesi_hub_pkg.sv
// Shared encodings of the coherence hub.
package mesi_hub_pkg;
    // Request kind on a master's request port; bit 1 marks a broadcast.
    typedef enum logic [1:0] {
        RQ_PLAIN_WR = 2'b00,
        RQ_PLAIN_RD = 2'b01,
        RQ_BCAST_WR = 2'b10,
        RQ_BCAST_RD = 2'b11
    } req_kind_e;

    // Phases of the single snoop engine.
    typedef enum logic [1:0] {
        ENG_IDLE  = 2'b00,
        ENG_SNOOP = 2'b01,
        ENG_WAIT  = 2'b10,
        ENG_GRANT = 2'b11
    } eng_state_e;
endpackage

// File: rtl/hub_req_fifo.sv
// Per-master request queue: first-in first-out storage of pending broadcasts.
// Assumes DEPTH is a power of two; push and pop may occur in the same cycle,
// the caller never pushes when full nor pops when empty.
module hub_req_fifo #(
    parameter int W     = 17,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    // Write the storage; no reset needed for data.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Head and status flags.
    always_comb begin
        dout  = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
    end
endmodule

// File: rtl/hub_prio_arb.sv
// Fixed-priority picker: the lowest-numbered candidate wins.
// Assumes nothing about the candidates; grant is one-hot or zero.
module hub_prio_arb #(
    parameter int N   = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] gid,
    output logic          any
);
    // Scan from index 0 upward and keep the first hit.
    always_comb begin
        grant = '0;
        gid   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && !any) begin
                grant[i] = 1'b1;
                gid      = IW'(i);
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hub_snoop_engine.sv
// Runs one coherence transaction: snoop fan-out, response collection, enable.
// Assumes start is only raised while idle is high and each master answers a
// snoop with a one-cycle acknowledge.
module hub_snoop_engine
    import mesi_hub_pkg::*;
#(
    parameter int N   = 4,
    parameter int AW  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] start_id,
    input  logic          start_wr,
    input  logic [AW-1:0] start_addr,
    input  logic [N-1:0]  ack,
    output logic          idle,
    output logic [N-1:0]  snp_vld,
    output logic          snp_wr,
    output logic [AW-1:0] snp_addr,
    output logic [N-1:0]  en_wr,
    output logic [N-1:0]  en_rd,
    output logic [N-1:0]  pend
);
    eng_state_e    state;
    logic [IW-1:0] init_id;
    logic          is_wr;
    logic [AW-1:0] addr_q;
    logic [N-1:0]  init_oh;
    logic [N-1:0]  pend_nx;

    // Decode the initiator and the remaining responders.
    always_comb begin
        init_oh = N'(1) << init_id;
        pend_nx = pend & ~ack;
    end

    // Phase sequencing and response mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ENG_IDLE;
            init_id <= '0;
            is_wr   <= 1'b0;
            addr_q  <= '0;
            pend    <= '0;
        end else begin
            case (state)
                ENG_IDLE: if (start) begin
                    state   <= ENG_SNOOP;
                    init_id <= start_id;
                    is_wr   <= start_wr;
                    addr_q  <= start_addr;
                    pend    <= ~(N'(1) << start_id);
                end
                ENG_SNOOP, ENG_WAIT: begin
                    pend  <= pend_nx;
                    state <= (pend_nx == '0) ? ENG_GRANT : ENG_WAIT;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Drive snoop and enable outputs from the phase.
    always_comb begin
        idle     = (state == ENG_IDLE);
        snp_vld  = (state == ENG_SNOOP) ? ~init_oh : '0;
        snp_wr   = is_wr;
        snp_addr = addr_q;
        en_wr    = (state == ENG_GRANT && is_wr)  ? init_oh : '0;
        en_rd    = (state == ENG_GRANT && !is_wr) ? init_oh : '0;
    end
endmodule

// File: rtl/mesi_hub.sv
// Coherence hub top: per-master queues, fixed-priority start, one snoop engine.
// Assumes masters hold a request for one cycle and resend nothing that was
// refused; plain accesses bypass the hub and are ignored here.
module mesi_hub
    import mesi_hub_pkg::*;
#(
    parameter int N_MST  = 4,
    parameter int AW     = 16,
    parameter int QDEPTH = 16,
    localparam int IW    = (N_MST > 1) ? $clog2(N_MST) : 1,
    localparam int CW    = $clog2(QDEPTH + 1),
    localparam int EW    = AW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_MST-1:0]    req_valid,
    input  logic [2*N_MST-1:0]  req_kind,
    input  logic [AW*N_MST-1:0] req_addr,
    output logic [N_MST-1:0]    req_ready,
    output logic [N_MST-1:0]    snoop_valid,
    output logic                snoop_inval,
    output logic [AW-1:0]       snoop_addr,
    input  logic [N_MST-1:0]    snoop_ack,
    output logic [N_MST-1:0]    enable_wr,
    output logic [N_MST-1:0]    enable_rd,
    output logic [CW*N_MST-1:0] queue_count
);
    logic [N_MST-1:0] q_empty, q_full, cand, grant;
    logic [EW-1:0]    cand_entry [N_MST];
    logic [IW-1:0]    gid;
    logic             any_cand, eng_idle;
    logic [N_MST-1:0] eng_pend;
    logic [EW-1:0]    start_entry;

    for (genvar i = 0; i < N_MST; i++) begin : g_mst
        logic          bcast, live_ok, take_live, push, pop;
        logic [EW-1:0] live_entry, head;
        logic [CW-1:0] cnt;

        // Classify the live request and decide queue traffic.
        always_comb begin
            bcast         = req_valid[i] & req_kind[2*i+1];
            live_ok       = bcast & ~q_full[i];
            live_entry    = {~req_kind[2*i], req_addr[AW*i +: AW]};
            cand[i]       = ~q_empty[i] | live_ok;
            cand_entry[i] = q_empty[i] ? live_entry : head;
            take_live     = live_ok & q_empty[i] & grant[i] & eng_idle;
            push          = live_ok & ~take_live;
            pop           = ~q_empty[i] & grant[i] & eng_idle;
        end

        hub_req_fifo #(.W(EW), .DEPTH(QDEPTH)) u_q (
            .clk(clk), .rst_n(rst_n), .push(push), .din(live_entry),
            .pop(pop), .dout(head), .empty(q_empty[i]), .full(q_full[i]),
            .count(cnt)
        );

        assign queue_count[CW*i +: CW] = cnt;
        assign req_ready[i]            = ~q_full[i];
    end

    hub_prio_arb #(.N(N_MST)) u_arb (
        .cand(cand), .grant(grant), .gid(gid), .any(any_cand)
    );

    // Select the winning entry for the engine.
    always_comb start_entry = cand_entry[gid];

    hub_snoop_engine #(.N(N_MST), .AW(AW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(any_cand & eng_idle), .start_id(gid),
        .start_wr(start_entry[EW-1]), .start_addr(start_entry[AW-1:0]),
        .ack(snoop_ack), .idle(eng_idle),
        .snp_vld(snoop_valid), .snp_wr(snoop_inval), .snp_addr(snoop_addr),
        .en_wr(enable_wr), .en_rd(enable_rd), .pend(eng_pend)
    );
endmodule

// File: rtl/mesi_hub_chk.sv
// Property checker for the coherence hub, bound into every instance.
module mesi_hub_chk #(
    parameter int N_MST  = 4,
    parameter int AW     = 16,
    parameter int QDEPTH = 16,
    localparam int CW    = $clog2(QDEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_MST-1:0]    req_ready,
    input logic [N_MST-1:0]    snoop_valid,
    input logic [N_MST-1:0]    enable_wr,
    input logic [N_MST-1:0]    enable_rd,
    input logic [CW*N_MST-1:0] queue_count,
    input logic [N_MST-1:0]    eng_pend
);
    // R5: at most one enable bit at a time.
    p_enable_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(enable_wr | enable_rd));

    // R5: no enable while any responder is still outstanding.
    p_enable_after_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(enable_wr | enable_rd)) |-> (eng_pend == '0));

    // R3: a snoop reaches every master but one.
    p_snoop_fanout_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|snoop_valid) |-> ($countones(snoop_valid) == N_MST - 1));

    // R3: the snoop is a single-cycle pulse.
    p_snoop_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|snoop_valid) |=> (snoop_valid == '0));

    // R9: snoop and enable phases never overlap.
    p_phase_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !((|snoop_valid) && (|(enable_wr | enable_rd))));

    for (genvar i = 0; i < N_MST; i++) begin : g_q
        // R8: ready drops only at a full queue.
        p_ready_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !req_ready[i] |-> (queue_count[CW*i +: CW] == CW'(QDEPTH)));
        // R10: occupancy never exceeds capacity.
        p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
            queue_count[CW*i +: CW] <= CW'(QDEPTH));
    end
endmodule

bind mesi_hub mesi_hub_chk #(.N_MST(N_MST), .AW(AW), .QDEPTH(QDEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .snoop_valid(snoop_valid),
    .enable_wr(enable_wr), .enable_rd(enable_rd), .queue_count(queue_count),
    .eng_pend(eng_pend)
);

// File: tb/sim_mesi_hub.sv
module sim_mesi_hub;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int AW = 16;
    localparam int CW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [2*N-1:0]  req_kind = '0;
    logic [AW*N-1:0] req_addr = '0;
    logic [N-1:0]    req_ready, snoop_valid, enable_wr, enable_rd;
    logic            snoop_inval;
    logic [AW-1:0]   snoop_addr;
    logic [N-1:0]    snoop_ack = '0;
    logic [CW*N-1:0] queue_count;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    mesi_hub u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_ready(req_ready), .snoop_valid(snoop_valid),
        .snoop_inval(snoop_inval), .snoop_addr(snoop_addr), .snoop_ack(snoop_ack),
        .enable_wr(enable_wr), .enable_rd(enable_rd), .queue_count(queue_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {master[1:0], kind[1:0], addr[15:0], snoop mask[3:0], inval}
    localparam logic [24:0] VEC [8] = '{
        {2'd0, 2'b10, 16'h1000, 4'b1110, 1'b1},
        {2'd1, 2'b11, 16'h2040, 4'b1101, 1'b0},
        {2'd2, 2'b10, 16'h3f00, 4'b1011, 1'b1},
        {2'd3, 2'b11, 16'habcd, 4'b0111, 1'b0},
        {2'd3, 2'b10, 16'h0004, 4'b0111, 1'b1},
        {2'd1, 2'b00, 16'h5555, 4'b0000, 1'b0},
        {2'd2, 2'b01, 16'h6666, 4'b0000, 1'b0},
        {2'd0, 2'b11, 16'hffff, 4'b1110, 1'b0}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic set_req(input int m, input logic [1:0] k, input logic [15:0] a);
        req_valid[m] = 1'b1;
        req_kind[2*m +: 2] = k;
        req_addr[AW*m +: AW] = a;
    endtask

    function automatic logic [31:0] qc(input int m);
        return 32'(queue_count[CW*m +: CW]);
    endfunction

    // Acknowledge the given mask for one cycle, then check the enable.
    task automatic finish_txn(input string rq, input int m, input logic inv);
        logic [N-1:0] oh;
        oh = N'(1) << m;
        snoop_ack = ~oh;
        @(negedge clk);
        snoop_ack = '0;
        chk(rq, {enable_wr, enable_rd}, inv ? {oh, 4'b0} : {4'b0, oh});
    endtask

    // Wait for the next snoop, check it, then complete the transaction.
    task automatic serve(input string rq, input int m, input logic inv, input logic [15:0] a);
        int w;
        w = 0;
        while (snoop_valid == '0 && w < 40) begin
            @(negedge clk);
            w++;
        end
        chk(rq, {snoop_valid, 3'b0, snoop_inval, snoop_addr}, {~(4'(1) << m), 3'b0, inv, a});
        finish_txn(rq, m, inv);
    endtask

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 ready", 32'(req_ready), 32'hf);
        chk("R1 counts", 32'(queue_count), 32'h0);
        chk("R1 outputs", {snoop_valid, enable_wr, enable_rd}, 32'h0);

        // Vector walk: R2, R3, R4, R5
        for (int v = 0; v < 8; v++) begin
            int m;
            logic [N-1:0] mask;
            m = int'(VEC[v][24:23]);
            mask = VEC[v][4:1];
            set_req(m, VEC[v][22:21], VEC[v][20:5]);
            @(negedge clk);
            req_valid = '0;
            if (mask == '0) begin
                for (int k = 0; k < 3; k++) begin
                    chk("R2 plain ignored", {snoop_valid, enable_wr, enable_rd}, 32'h0);
                    @(negedge clk);
                end
                chk("R2 no queue", 32'(queue_count), 32'h0);
            end else begin
                chk(VEC[v][0] ? "R3 write snoop" : "R4 read snoop",
                    {snoop_valid, 3'b0, snoop_inval, snoop_addr},
                    {mask, 3'b0, VEC[v][0], VEC[v][20:5]});
                finish_txn("R5 enable", m, VEC[v][0]);
                @(negedge clk);
            end
        end

        // R5: partial and repeated acknowledges do not grant
        set_req(2, 2'b10, 16'h0c0c);
        @(negedge clk);
        req_valid = '0;
        chk("R5 snoop", 32'(snoop_valid), 32'hb);
        snoop_ack = 4'b0101;
        @(negedge clk);
        snoop_ack = '0;
        repeat (2) @(negedge clk);
        chk("R5 no early enable", {enable_wr, enable_rd}, 32'h0);
        snoop_ack = 4'b0110;
        @(negedge clk);
        snoop_ack = '0;
        chk("R5 initiator ack ignored", {enable_wr, enable_rd}, 32'h0);
        snoop_ack = 4'b1000;
        @(negedge clk);
        snoop_ack = '0;
        chk("R5 enable after last", {enable_wr, enable_rd}, {4'b0100, 4'b0});
        @(negedge clk);

        // R6: simultaneous requests, lowest index first
        for (int m = 0; m < N; m++) set_req(m, 2'b10, 16'h0800);
        @(negedge clk);
        req_valid = '0;
        chk("R6 master0 wins", 32'(snoop_valid), 32'he);
        chk("R6 counts", 32'(queue_count), {12'b0, 5'd1, 5'd1, 5'd1, 5'd0});
        finish_txn("R6 m0 enable", 0, 1'b1);
        serve("R6 m1", 1, 1'b1, 16'h0800);
        serve("R6 m2", 2, 1'b1, 16'h0800);
        serve("R6 m3", 3, 1'b1, 16'h0800);
        @(negedge clk);

        // R7 / R9: requests during a busy transaction queue in order
        set_req(3, 2'b11, 16'h0a00);
        @(negedge clk);
        req_valid = '0;
        chk("R9 first snoop", 32'(snoop_valid), 32'h7);
        set_req(1, 2'b10, 16'h0b01);
        @(negedge clk);
        set_req(1, 2'b11, 16'h0b02);
        @(negedge clk);
        req_valid = '0;
        chk("R10 count two", qc(1), 32'd2);
        chk("R9 no second snoop", 32'(snoop_valid), 32'h0);
        finish_txn("R9 m3 enable", 3, 1'b0);
        serve("R7 head first", 1, 1'b1, 16'h0b01);
        serve("R7 second", 1, 1'b0, 16'h0b02);
        @(negedge clk);
        chk("R10 drained", qc(1), 32'd0);

        // R8: fill one queue and offer one more
        set_req(0, 2'b10, 16'h0100);
        @(negedge clk);
        req_valid = '0;
        for (int k = 0; k < 17; k++) begin
            set_req(2, 2'b11, 16'h0200 + 16'(k));
            @(negedge clk);
        end
        req_valid = '0;
        chk("R8 count full", qc(2), 32'd16);
        chk("R8 ready low", 32'(req_ready), 32'hb);
        finish_txn("R8 m0 enable", 0, 1'b1);
        for (int k = 0; k < 16; k++) serve("R8 drain order", 2, 1'b0, 16'h0200 + 16'(k));
        repeat (4) @(negedge clk);
        chk("R8 extra dropped", {snoop_valid, 8'b0, 12'(queue_count)}, 32'h0);
        chk("R8 ready back", 32'(req_ready), 32'hf);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule